// File: doc/BRIEF.md
# SPI Serial NOR Flash Device Model

This block is a synthesizable slave-side model of a small serial NOR flash. It watches a serial clock, a serial data input and an active-low select, all oversampled on the system clock, and decodes 8-bit bus cycles: a command byte, then address or data bytes as the command needs. It answers on a serial data output. Every output bit changes after a falling serial clock edge, so a host may use SPI mode 0 or mode 3.

The model supports six commands. Streaming read, sector erase and byte program each take three address bytes. Chip erase takes only the command byte. The status read reports whether an internal job is still running. The identity read returns one of two fixed codes, selected by the lowest address bit. The storage is an internal byte array written through one port, so an FPGA can place it in block RAM. Erase and program times are cycle counts set by parameters.

A write-protect input must be high for an erase or program to be accepted. A separate active-low reset pin aborts any running job and any frame in progress. The system reset `rst` is synchronous and active high.

Top module: `sflash_model`

## Requirements
- R1: Each bus cycle is 8 bits, most significant bit first. Input bits are taken on the rising serial clock. Output bits change after the falling serial clock. A frame works whether the serial clock idles low (mode 0) or high (mode 3) when select falls.
- R2: Command FFh followed by three address bytes (A23..A0) streams bytes from that address, one byte per cycle, with the address incrementing automatically. Address bits at and above MEM_AW are ignored.
- R3: A read that passes the top address (2^MEM_AW - 1) continues from address 0 and keeps streaming until select rises.
- R4: Command 9Fh returns a status byte repeatedly while the clock runs. Bit 0 is 1 when the device is idle and 0 while an erase or program is running. All other bits are 0.
- R5: Command 90h followed by three address bytes returns DAh repeatedly when A0 = 0 and 98h when A0 = 1.
- R6: Command 10h, three address bytes and one data byte stores (old AND new) at that address. The write is accepted only when the fifth byte completes.
- R7: Command 20h with three address bytes sets every byte of the sector to FFh. The sector is selected by address bits [MEM_AW-1:SECT_AW] and is 2^SECT_AW bytes long. Bytes outside the sector are untouched.
- R8: Command 60h sets the whole array to FFh.
- R9: When the write-protect input is low, erase and program commands have no effect: the status stays ready and the stored data is unchanged.
- R10: If select rises before a command's last byte completes, the command has no effect.
- R11: While a job is running, every command except status read is ignored. The output stays 0 and the stored data is unchanged.
- R12: Driving the reset pin low aborts a running job, so the status reads ready afterwards. It also kills the current frame: the device stays silent until select falls again.
- R13: The output is 0 while select is high, after reset, and outside the output phase of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high system reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low device select |
| si_i | input | 1 | Serial data from the host |
| so_o | output | 1 | Serial data to the host |
| wp_i | input | 1 | Write enable gate; high allows erase and program |
| hw_rst_n_i | input | 1 | Active-low device reset pin |

## Verification
The hardest state to reach is a command that arrives while a job is running. Busy windows are only a few cycles long for a program, and the host cannot see them except through status polling. The stimulus therefore starts a sector erase, which lasts thousands of cycles. It confirms busy with one status frame and then fires a program and an identity read into that window before polling for ready. The reset-pin cases use the same approach. A chip erase is started and reset part way, and a separate read frame is cut by the reset pin while select stays low, to show the frame stays dead until a new select edge.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  // Command codes; decoded from the first byte of every frame.
  typedef enum logic [7:0] {
    OP_NONE = 8'h00,
    OP_PROG = 8'h10,
    OP_SECT = 8'h20,
    OP_CHIP = 8'h60,
    OP_ID   = 8'h90,
    OP_STAT = 8'h9F,
    OP_READ = 8'hFF
  } op_e;

  typedef enum logic [1:0] {
    JOB_IDLE,
    JOB_PROG,
    JOB_SECT,
    JOB_CHIP
  } job_e;

  localparam logic [7:0] ID_CODE_LO = 8'hDA;
  localparam logic [7:0] ID_CODE_HI = 8'h98;

  function automatic op_e op_decode(input logic [7:0] b);
    case (b)
      8'h10:   return OP_PROG;
      8'h20:   return OP_SECT;
      8'h60:   return OP_CHIP;
      8'h90:   return OP_ID;
      8'h9F:   return OP_STAT;
      8'hFF:   return OP_READ;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sflash_sync.sv
// One register stage on asynchronous pins; reset value per bit.
module sflash_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= din;
  end
endmodule

// File: rtl/sflash_array.sv
// Byte array: one write port, one registered read port (block RAM shape).
module sflash_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sflash_engine.sv
// Busy timer and write sequencer for program / sector erase / chip erase.
module sflash_engine
  import sflash_pkg::*;
#(
  parameter int AW       = 10,
  parameter int SAW      = 7,
  parameter int CHIP_CYC = 20000,
  parameter int SECT_CYC = 5000,
  parameter int PROG_CYC = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  job_e              job_in,
  input  logic [AW-SAW-1:0] sect_in,
  input  logic [AW-1:0]     paddr_in,
  output logic              busy,
  output job_e              job,
  output logic              we,
  output logic [AW-1:0]     waddr
);
  localparam int MEM_BYTES  = 1 << AW;
  localparam int SECT_BYTES = 1 << SAW;
  localparam int CHIP_LEN   = (CHIP_CYC > MEM_BYTES)  ? CHIP_CYC : MEM_BYTES + 1;
  localparam int SECT_LEN   = (SECT_CYC > SECT_BYTES) ? SECT_CYC : SECT_BYTES + 1;
  localparam int PROG_LEN   = (PROG_CYC > 3) ? PROG_CYC : 3;
  localparam int MAX_A      = (CHIP_LEN > SECT_LEN) ? CHIP_LEN : SECT_LEN;
  localparam int MAX_LEN    = (MAX_A > PROG_LEN) ? MAX_A : PROG_LEN;
  localparam int CW         = $clog2(MAX_LEN + 1);

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lim;
  logic [AW-SAW-1:0] sect_r;
  logic [AW-1:0]     paddr_r;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      job  <= JOB_IDLE;
      cnt  <= '0;
      lim  <= '0;
    end else if (!busy) begin
      if (start && job_in != JOB_IDLE) begin
        busy    <= 1'b1;
        job     <= job_in;
        cnt     <= '0;
        sect_r  <= sect_in;
        paddr_r <= paddr_in;
        case (job_in)
          JOB_CHIP: lim <= CW'(CHIP_LEN);
          JOB_SECT: lim <= CW'(SECT_LEN);
          default:  lim <= CW'(PROG_LEN);
        endcase
      end
    end else if (cnt == lim - 1'b1) begin
      busy <= 1'b0;
      job  <= JOB_IDLE;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Program: address held from cycle 0, old byte valid at cycle 1, write at 2.
  // Erase: one byte per cycle from the start of the window.
  always_comb begin
    we    = 1'b0;
    waddr = paddr_r;
    case (job)
      JOB_PROG: we = busy && (cnt == CW'(2));
      JOB_SECT: begin
        we    = busy && (cnt < CW'(SECT_BYTES));
        waddr = {sect_r, cnt[SAW-1:0]};
      end
      JOB_CHIP: begin
        we    = busy && (cnt < CW'(MEM_BYTES));
        waddr = cnt[AW-1:0];
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/sflash_model.sv
module sflash_model
  import sflash_pkg::*;
#(
  parameter int MEM_AW   = 10,
  parameter int SECT_AW  = 7,
  parameter int CHIP_CYC = 20000,
  parameter int SECT_CYC = 5000,
  parameter int PROG_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic so_o,
  input  logic wp_i,
  input  logic hw_rst_n_i
);
  localparam int SEC_W = MEM_AW - SECT_AW;

  // Pin order: {hw_rst_n, wp, si, cs_n, sck}
  logic [4:0] pins_q;
  logic       sck_d, cs_d;

  sflash_sync #(.W(5), .RST_VAL(5'b11010)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({hw_rst_n_i, wp_i, si_i, cs_n_i, sck_i}),
    .q   (pins_q)
  );

  logic sck_s, cs_s, si_s, wp_s, hw_ok;
  assign sck_s = pins_q[0];
  assign cs_s  = pins_q[1];
  assign si_s  = pins_q[2];
  assign wp_s  = pins_q[3];
  assign hw_ok = pins_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, cs_fall;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;

  // Frame state
  logic              act;
  logic [2:0]        bit_idx;
  logic [2:0]        byte_cnt;
  logic [6:0]        sh_in;
  op_e               cmd;
  logic [MEM_AW-1:0] ptr;
  logic [7:0]        id_byte;
  logic [7:0]        prog_data;
  logic [7:0]        sh_out;
  logic              so_r;

  // Engine / array links
  logic              busy, mem_we;
  job_e              eng_job;
  logic [MEM_AW-1:0] eng_waddr;
  logic [7:0]        mem_q, mem_wdata;

  logic [7:0]        in_byte;
  logic [MEM_AW-1:0] addr_next;
  logic              byte_done, out_phase;
  logic              st_chip, st_sect, st_prog;
  job_e              start_job;
  logic [7:0]        load_val;

  assign in_byte   = {sh_in, si_s};
  assign addr_next = MEM_AW'({ptr, in_byte});
  assign byte_done = act && hw_ok && !cs_s && sck_rise && (bit_idx == 3'd7);

  assign st_chip = byte_done && (byte_cnt == 3'd0) && (op_decode(in_byte) == OP_CHIP)
                   && wp_s && !busy;
  assign st_sect = byte_done && (byte_cnt == 3'd3) && (cmd == OP_SECT) && wp_s && !busy;
  assign st_prog = byte_done && (byte_cnt == 3'd4) && (cmd == OP_PROG) && wp_s && !busy;

  always_comb begin
    if (st_chip)      start_job = JOB_CHIP;
    else if (st_sect) start_job = JOB_SECT;
    else if (st_prog) start_job = JOB_PROG;
    else              start_job = JOB_IDLE;
  end

  assign out_phase = act && (((cmd == OP_STAT) && (byte_cnt != 3'd0)) ||
                             (((cmd == OP_READ) || (cmd == OP_ID)) && (byte_cnt >= 3'd4)));

  always_comb begin
    case (cmd)
      OP_READ: load_val = mem_q;
      OP_ID:   load_val = id_byte;
      OP_STAT: load_val = {7'd0, ~busy};
      default: load_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !hw_ok) begin
      act      <= 1'b0;
      bit_idx  <= '0;
      byte_cnt <= '0;
      cmd      <= OP_NONE;
      sh_out   <= '0;
      so_r     <= 1'b0;
    end else if (cs_s) begin
      act  <= 1'b0;
      so_r <= 1'b0;
    end else if (cs_fall) begin
      act      <= 1'b1;
      bit_idx  <= '0;
      byte_cnt <= '0;
      cmd      <= OP_NONE;
      so_r     <= 1'b0;
    end else if (act) begin
      if (sck_rise) begin
        sh_in   <= in_byte[6:0];
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == 3'd7) begin
          if (byte_cnt != 3'd5) byte_cnt <= byte_cnt + 1'b1;
          case (byte_cnt)
            3'd0: begin
              if (busy && op_decode(in_byte) != OP_STAT) cmd <= OP_NONE;
              else                                       cmd <= op_decode(in_byte);
            end
            3'd1, 3'd2: ptr <= addr_next;
            3'd3: begin
              ptr     <= addr_next;
              id_byte <= in_byte[0] ? ID_CODE_HI : ID_CODE_LO;
            end
            3'd4: prog_data <= in_byte;
            default: ;
          endcase
        end
      end else if (sck_fall && out_phase) begin
        if (bit_idx == 3'd0) begin
          so_r   <= load_val[7];
          sh_out <= {load_val[6:0], 1'b0};
          if (cmd == OP_READ) ptr <= ptr + 1'b1;
        end else begin
          so_r   <= sh_out[7];
          sh_out <= {sh_out[6:0], 1'b0};
        end
      end
    end
  end

  assign so_o = so_r;

  sflash_engine #(
    .AW       (MEM_AW),
    .SAW      (SECT_AW),
    .CHIP_CYC (CHIP_CYC),
    .SECT_CYC (SECT_CYC),
    .PROG_CYC (PROG_CYC)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .abort    (!hw_ok),
    .start    (start_job != JOB_IDLE),
    .job_in   (start_job),
    .sect_in  (addr_next[MEM_AW-1:SECT_AW]),
    .paddr_in (ptr),
    .busy     (busy),
    .job      (eng_job),
    .we       (mem_we),
    .waddr    (eng_waddr)
  );

  assign mem_wdata = (eng_job == JOB_PROG) ? (mem_q & prog_data) : 8'hFF;

  sflash_array #(.AW(MEM_AW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (eng_waddr),
    .wdata (mem_wdata),
    .raddr (busy ? eng_waddr : ptr),
    .rdata (mem_q)
  );

  logic [SEC_W-1:0] unused_sec;
  assign unused_sec = '0;
endmodule

// File: rtl/sflash_model_chk.sv
module sflash_model_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_i,
  input logic so_o,
  input logic wp_i,
  input logic hw_rst_n_i,
  input logic busy,
  input logic act
);
  // R13
  so_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !so_o);

  // R12
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_rst_n_i |-> ##2 !busy);

  // R9
  wp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wp_i, 2));

  // R10
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(act));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
endmodule

bind sflash_model sflash_model_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n_i     (cs_n_i),
  .so_o       (so_o),
  .wp_i       (wp_i),
  .hw_rst_n_i (hw_rst_n_i),
  .busy       (busy),
  .act        (act)
);

// File: tb/tb_sflash_model.sv
module tb_sflash_model;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int SECTB = 128;
  localparam int H     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp = 1'b1, hwr = 1'b1;
  logic so;

  always #2 clk = ~clk;

  sflash_model dut (
    .clk (clk), .rst (rst), .sck_i (sck), .cs_n_i (cs_n),
    .si_i (si), .so_o (so), .wp_i (wp), .hw_rst_n_i (hwr)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycle monitor: with select high for a while, the output must sit at 0 (R13)
  logic [1:0] cs_hist = 2'b00;
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n && cs_hist == 2'b11) chk(so == 1'b0, "R13 idle", so, 0);
      cs_hist <= {cs_hist[0], cs_n};
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i];
      clks(H);
      rx = {rx[6:0], so};
      sck = 1'b1;
      clks(H);
    end
  endtask

  task automatic fstart(input bit m3);
    sck = m3; clks(4); cs_n = 1'b0; clks(4);
  endtask

  task automatic fend();
    clks(4); cs_n = 1'b1; clks(8); sck = 1'b0; clks(4);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    spi_byte(op, r); spi_byte(a[23:16], r); spi_byte(a[15:8], r); spi_byte(a[7:0], r);
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input bit m3, input string req);
    logic [7:0] r;
    fstart(m3);
    send_hdr(8'hFF, a);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, r);
      chk(r == ref_mem[(int'(a) + i) % DEPTH], req, r, ref_mem[(int'(a) + i) % DEPTH]);
    end
    fend();
  endtask

  task automatic do_status(input logic [7:0] exp, input int n, input string req);
    logic [7:0] r;
    fstart(1'b0);
    spi_byte(8'h9F, r);
    for (int i = 0; i < n; i++) begin
      spi_byte(8'h00, r);
      chk(r == exp, req, r, exp);
    end
    fend();
  endtask

  task automatic do_id(input logic [23:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r;
    fstart(1'b0);
    send_hdr(8'h90, a);
    for (int i = 0; i < 2; i++) begin
      spi_byte(8'h00, r);
      chk(r == exp, req, r, exp);
    end
    fend();
  endtask

  task automatic do_prog(input logic [23:0] a, input logic [7:0] d, input bit takes);
    logic [7:0] r;
    fstart(1'b0);
    send_hdr(8'h10, a);
    spi_byte(d, r);
    fend();
    if (takes) ref_mem[int'(a) % DEPTH] = ref_mem[int'(a) % DEPTH] & d;
  endtask

  task automatic do_sect(input logic [23:0] a, input bit takes);
    fstart(1'b0);
    send_hdr(8'h20, a);
    fend();
    if (takes) begin
      int base = (int'(a) % DEPTH) / SECTB * SECTB;
      for (int i = 0; i < SECTB; i++) ref_mem[base + i] = 8'hFF;
    end
  endtask

  task automatic do_chip(input bit takes);
    logic [7:0] r;
    fstart(1'b0);
    spi_byte(8'h60, r);
    fend();
    if (takes) for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
  endtask

  task automatic wait_ready(input string req);
    logic [7:0] r;
    bit ok = 1'b0;
    for (int p = 0; p < 300 && !ok; p++) begin
      fstart(1'b0);
      spi_byte(8'h9F, r);
      spi_byte(8'h00, r);
      fend();
      if (r == 8'h01) ok = 1'b1;
      else clks(200);
    end
    chk(ok, req, r, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    clks(6);
    rst = 1'b0;
    clks(2);
    chk(so == 1'b0, "R13 reset", so, 0);

    // R6: programming ANDs into the stored byte
    do_prog(24'h000005, 8'hA5, 1'b1); wait_ready("R6 ready");
    do_prog(24'h000005, 8'h3C, 1'b1); wait_ready("R6 ready");
    do_prog(24'h0003FF, 8'h11, 1'b1); wait_ready("R6 ready");
    do_prog(24'h000000, 8'h22, 1'b1); wait_ready("R6 ready");
    do_prog(24'h000080, 8'h77, 1'b1); wait_ready("R6 ready");
    do_read(24'h000003, 4, 1'b0, "R6 R2 read");

    // R2: upper address bits ignored; R1 + R3: mode 3 with wrap
    do_read(24'hFEF405, 2, 1'b0, "R2 upper bits");
    do_read(24'h0003FE, 4, 1'b1, "R1 R3 wrap mode3");

    // R4 idle status, R5 identity codes
    do_status(8'h01, 3, "R4 ready");
    do_id(24'h000000, 8'hDA, "R5 low");
    do_id(24'h000001, 8'h98, "R5 high");

    // R9: write gate low
    wp = 1'b0;
    do_prog(24'h000010, 8'h00, 1'b0);
    do_sect(24'h000380, 1'b0);
    do_status(8'h01, 1, "R9 no job");
    wp = 1'b1;
    do_read(24'h000010, 1, 1'b0, "R9 prog blocked");
    do_read(24'h0003FF, 1, 1'b0, "R9 erase blocked");

    // R10: select rises before the data byte
    fstart(1'b0);
    send_hdr(8'h10, 24'h000020);
    fend();
    do_status(8'h01, 1, "R10 no job");
    do_read(24'h000020, 1, 1'b0, "R10 unchanged");

    // R7 sector erase, R11 commands during busy
    do_sect(24'h000040, 1'b1);
    do_status(8'h00, 2, "R4 busy");
    do_prog(24'h0003FF, 8'h00, 1'b0);
    do_id(24'h000000, 8'h00, "R11 id ignored");
    wait_ready("R7 ready");
    do_read(24'h00007E, 4, 1'b0, "R7 sector edge");
    do_read(24'h000003, 4, 1'b0, "R7 sector body");
    do_read(24'h0003FF, 1, 1'b0, "R11 prog ignored");

    // R12: reset pin aborts a chip erase
    do_prog(24'h000200, 8'h5A, 1'b1); wait_ready("R6 ready");
    do_chip(1'b0);
    do_status(8'h00, 1, "R12 busy before");
    hwr = 1'b0; clks(10); hwr = 1'b1; clks(4);
    do_status(8'h01, 1, "R12 ready after");

    // R12: frame killed mid-way stays silent
    fstart(1'b0);
    send_hdr(8'hFF, 24'h000000);
    hwr = 1'b0; clks(10); hwr = 1'b1; clks(4);
    for (int i = 0; i < 2; i++) begin
      spi_byte(8'h00, r);
      chk(r == 8'h00, "R12 dead frame", r, 0);
    end
    fend();

    // R8: full chip erase
    do_chip(1'b1);
    do_status(8'h00, 1, "R4 busy chip");
    wait_ready("R8 ready");
    do_read(24'h0003FE, 4, 1'b0, "R8 erased wrap");
    do_read(24'h000200, 1, 1'b0, "R8 erased mid");
    do_read(24'h000080, 1, 1'b1, "R8 erased");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule